// File: doc/BRIEF.md
# Upper-Memory Shadow Routing Configuration Block

This block is the configuration register file of a PC-style chipset. Software reaches it through two byte-wide I/O locations. A write to the index location selects one of eighteen 8-bit configuration registers. A write to the data location then stores a byte into the selected register, and a read of the data location returns that register. Some registers drop certain bits when they are written.

Four of the registers control the chipset. Three of them decide where each memory access in the upper memory window C0000h–FFFFFh is routed. For each access, reads can go to internal DRAM or to the external expansion bus, and writes are routed separately. The C and D segments are split into four 16 KB granules each. The E and F segments are handled as whole 64 KB blocks. A memory-side client presents a 20-bit address with a valid strobe and gets back two routing flags in the same cycle. A fourth register supplies an external-cache enable flag.

After reset every register and the index are zero, so the whole window routes to the external bus. A register write changes the routing flags from the cycle after that write is accepted.

Top module: `chipset_shadow_cfg`

## Requirements
- R1: A write to I/O address 22h loads the index. A following write to I/O address 24h stores the data byte into the register selected by that index, and the stored value can be read back.
- R2: A read of I/O address 24h returns the register selected by the index. Any other address returns FFh.
- R3: Only indices 00h–11h hold storage. A data write under any index from 12h to FFh changes no register, and a read under such an index returns 00h.
- R4: A write to register 00h keeps only bits 6:0 (mask 7Fh). A write to register 0Ch keeps only the bits under mask CFh. Every other implemented register keeps the whole byte.
- R5: Register 04h routes C0000h–CFFFFh and register 05h routes D0000h–DFFFFh. Address bits 15:14 select granule g, and register bits [2g+1:2g] control it. Bit 2g set sends reads to DRAM and bit 2g+1 set sends writes to DRAM.
- R6: For E0000h–EFFFFh, register 06h bit 0 routes reads and bit 1 routes writes to DRAM. For F0000h–FFFFFh, bits 2 and 3 do the same.
- R7: Both routing flags are low when the valid strobe is low or the address is below C0000h.
- R8: The cache-enable output is high exactly when bit 2 or bit 3 of register 02h is set.
- R9: After reset all registers and the index read as 00h, and the whole window routes to the external bus.
- R10: A data write changes the routing flags from the next clock cycle on. In the cycle in which the write is accepted, the flags still show the old setting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_addr | input | 16 | I/O address of the current access |
| io_wr | input | 1 | Single-cycle I/O write strobe |
| io_rd | input | 1 | Single-cycle I/O read strobe |
| io_wdata | input | 8 | I/O write data |
| io_rdata | output | 8 | Combinational I/O read data |
| mem_addr | input | 20 | Memory address to route |
| mem_valid | input | 1 | Memory address is valid |
| read_internal | output | 1 | Read at mem_addr goes to internal DRAM |
| write_internal | output | 1 | Write at mem_addr goes to internal DRAM |
| cache_ext_en | output | 1 | External cache enable |

## Verification
The bench builds the block with its default parameters: eighteen registers, index port 22h, data port 24h and a 20-bit memory address. With these values every 16 KB granule of the C and D segments and both 64 KB segments at E and F can be reached from the address input. The index can also be driven anywhere in the unimplemented range 12h–FFh, which lets the bench confirm that writes there leave the register file untouched. The masked registers 00h and 0Ch, and the first-cycle timing of a routing update, are checked by directed tests.

// File: rtl/shadow_cfg_pkg.sv
package shadow_cfg_pkg;
  localparam int CFG_REGS   = 18;
  localparam int SEL_CACHE  = 2;
  localparam int SEL_SEG_C  = 4;
  localparam int SEL_SEG_D  = 5;
  localparam int SEL_SEG_EF = 6;

  // Bits a write may set in register i.
  function automatic logic [7:0] keep_mask(int unsigned i);
    case (i)
      0:       keep_mask = 8'h7F;
      12:      keep_mask = 8'hCF;
      default: keep_mask = 8'hFF;
    endcase
  endfunction

  typedef struct packed {
    logic wr_dram;
    logic rd_dram;
  } route_t;
endpackage

// File: rtl/shadow_cfg_regfile.sv
module shadow_cfg_regfile
  import shadow_cfg_pkg::*;
#(
  parameter int          IO_AW    = 16,
  parameter int          DW       = 8,
  parameter int          NREGS    = CFG_REGS,
  parameter logic [15:0] IDX_PORT = 16'h0022,
  parameter logic [15:0] DAT_PORT = 16'h0024
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [IO_AW-1:0]         io_addr,
  input  logic                     io_wr,
  input  logic                     io_rd,
  input  logic [DW-1:0]            io_wdata,
  output logic [DW-1:0]            io_rdata,
  output logic [DW-1:0]            idx_o,
  output logic [NREGS-1:0][DW-1:0] regs_o
);
  localparam logic [IO_AW-1:0] IDX_A = IO_AW'(IDX_PORT);
  localparam logic [IO_AW-1:0] DAT_A = IO_AW'(DAT_PORT);

  logic                     idx_wr, dat_wr, dat_rd;
  logic [DW-1:0]            idx_q;
  logic [NREGS-1:0][DW-1:0] regs_q;
  logic [DW-1:0]            sel_val;

  assign idx_wr = io_wr && (io_addr == IDX_A);
  assign dat_wr = io_wr && (io_addr == DAT_A);
  assign dat_rd = io_rd && (io_addr == DAT_A);

  always_ff @(posedge clk) begin
    if (rst)         idx_q <= '0;
    else if (idx_wr) idx_q <= io_wdata;
  end

  for (genvar g = 0; g < NREGS; g++) begin : g_reg
    localparam logic [DW-1:0] KEEP = DW'(keep_mask(g));
    always_ff @(posedge clk) begin
      if (rst)
        regs_q[g] <= '0;
      else if (dat_wr && idx_q == DW'(g))
        regs_q[g] <= io_wdata & KEEP;
    end
  end

  always_comb begin
    sel_val = '0;
    for (int i = 0; i < NREGS; i++)
      if (idx_q == DW'(i)) sel_val = regs_q[i];
  end

  assign io_rdata = dat_rd ? sel_val : '1;
  assign idx_o    = idx_q;
  assign regs_o   = regs_q;
endmodule

// File: rtl/shadow_route_decode.sv
module shadow_route_decode
  import shadow_cfg_pkg::*;
#(
  parameter int MAW = 20,
  parameter int DW  = 8
) (
  input  logic [MAW-1:0] mem_addr,
  input  logic           mem_valid,
  input  logic [DW-1:0]  seg_c,
  input  logic [DW-1:0]  seg_d,
  input  logic [3:0]     seg_ef,
  output logic           rd_dram,
  output logic           wr_dram
);
  localparam int GRANS = 4;

  logic [3:0]  seg_sel;
  logic [1:0]  gran;
  route_t      c_fld [GRANS];
  route_t      d_fld [GRANS];
  route_t      pick;
  logic        unused_low;

  assign seg_sel    = mem_addr[MAW-1 -: 4];
  assign gran       = mem_addr[MAW-5 -: 2];
  assign unused_low = ^mem_addr[MAW-7:0];

  for (genvar g = 0; g < GRANS; g++) begin : g_gran
    assign c_fld[g] = '{wr_dram: seg_c[2*g+1], rd_dram: seg_c[2*g]};
    assign d_fld[g] = '{wr_dram: seg_d[2*g+1], rd_dram: seg_d[2*g]};
  end

  always_comb begin
    case (seg_sel)
      4'hC:    pick = c_fld[gran];
      4'hD:    pick = d_fld[gran];
      4'hE:    pick = '{wr_dram: seg_ef[1], rd_dram: seg_ef[0]};
      4'hF:    pick = '{wr_dram: seg_ef[3], rd_dram: seg_ef[2]};
      default: pick = '0;
    endcase
  end

  assign rd_dram = mem_valid && pick.rd_dram;
  assign wr_dram = mem_valid && pick.wr_dram;
endmodule

// File: rtl/chipset_shadow_cfg.sv
module chipset_shadow_cfg
  import shadow_cfg_pkg::*;
#(
  parameter int          IO_AW    = 16,
  parameter int          DW       = 8,
  parameter int          MAW      = 20,
  parameter int          NREGS    = CFG_REGS,
  parameter logic [15:0] IDX_PORT = 16'h0022,
  parameter logic [15:0] DAT_PORT = 16'h0024
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IO_AW-1:0] io_addr,
  input  logic             io_wr,
  input  logic             io_rd,
  input  logic [DW-1:0]    io_wdata,
  output logic [DW-1:0]    io_rdata,
  input  logic [MAW-1:0]   mem_addr,
  input  logic             mem_valid,
  output logic             read_internal,
  output logic             write_internal,
  output logic             cache_ext_en
);
  logic [DW-1:0]            cfg_idx;
  logic [NREGS-1:0][DW-1:0] cfg_regs;
  logic                     unused_cfg;

  shadow_cfg_regfile #(
    .IO_AW(IO_AW), .DW(DW), .NREGS(NREGS),
    .IDX_PORT(IDX_PORT), .DAT_PORT(DAT_PORT)
  ) u_regs (
    .clk(clk), .rst(rst),
    .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
    .io_wdata(io_wdata), .io_rdata(io_rdata),
    .idx_o(cfg_idx), .regs_o(cfg_regs)
  );

  shadow_route_decode #(.MAW(MAW), .DW(DW)) u_route (
    .mem_addr(mem_addr), .mem_valid(mem_valid),
    .seg_c(cfg_regs[SEL_SEG_C]), .seg_d(cfg_regs[SEL_SEG_D]),
    .seg_ef(cfg_regs[SEL_SEG_EF][3:0]),
    .rd_dram(read_internal), .wr_dram(write_internal)
  );

  assign cache_ext_en = cfg_regs[SEL_CACHE][2] || cfg_regs[SEL_CACHE][3];
  assign unused_cfg   = ^{cfg_idx, cfg_regs};
endmodule

// File: rtl/shadow_cfg_chk.sv
module shadow_cfg_chk
  import shadow_cfg_pkg::*;
#(
  parameter int          IO_AW    = 16,
  parameter int          DW       = 8,
  parameter int          MAW      = 20,
  parameter int          NREGS    = CFG_REGS,
  parameter logic [15:0] IDX_PORT = 16'h0022,
  parameter logic [15:0] DAT_PORT = 16'h0024
) (
  input logic                     clk,
  input logic                     rst,
  input logic [IO_AW-1:0]         io_addr,
  input logic                     io_wr,
  input logic [DW-1:0]            io_wdata,
  input logic [DW-1:0]            io_rdata,
  input logic [MAW-1:0]           mem_addr,
  input logic                     mem_valid,
  input logic                     read_internal,
  input logic                     write_internal,
  input logic                     cache_ext_en,
  input logic [DW-1:0]            cfg_idx,
  input logic [NREGS-1:0][DW-1:0] cfg_regs
);
  logic idx_w, dat_w;
  assign idx_w = io_wr && io_addr == IO_AW'(IDX_PORT);
  assign dat_w = io_wr && io_addr == IO_AW'(DAT_PORT);

  assert_index_load_R1: assert property (@(posedge clk) disable iff (rst)
    idx_w |=> cfg_idx == $past(io_wdata));

  assert_other_port_R2: assert property (@(posedge clk) disable iff (rst)
    (io_addr != IO_AW'(DAT_PORT)) |-> io_rdata == '1);

  assert_gap_ignored_R3: assert property (@(posedge clk) disable iff (rst)
    (dat_w && cfg_idx >= DW'(NREGS)) |=> $stable(cfg_regs));

  assert_mask_reg0_R4: assert property (@(posedge clk) disable iff (rst)
    (dat_w && cfg_idx == '0) |=> cfg_regs[0] == ($past(io_wdata) & DW'(8'h7F)));

  assert_low_window_R7: assert property (@(posedge clk) disable iff (rst)
    (!mem_valid || mem_addr[MAW-1 -: 2] != 2'b11) |-> (!read_internal && !write_internal));

  assert_cache_flag_R8: assert property (@(posedge clk) disable iff (rst)
    (dat_w && cfg_idx == DW'(SEL_CACHE)) |=> cache_ext_en == (($past(io_wdata) & DW'(8'h0C)) != '0));

  assert_no_write_stable_R10: assert property (@(posedge clk) disable iff (rst)
    !dat_w |=> $stable(cfg_regs));
endmodule

bind chipset_shadow_cfg shadow_cfg_chk #(
  .IO_AW(IO_AW), .DW(DW), .MAW(MAW), .NREGS(NREGS),
  .IDX_PORT(IDX_PORT), .DAT_PORT(DAT_PORT)
) i_chk (.*);

// File: tb/test_chipset_shadow_cfg.sv
module test_chipset_shadow_cfg;
  logic        clk = 0;
  logic        rst = 1;
  logic [15:0] io_addr = '0;
  logic        io_wr = 0, io_rd = 0;
  logic [7:0]  io_wdata = '0;
  logic [7:0]  io_rdata;
  logic [19:0] mem_addr = '0;
  logic        mem_valid = 0;
  logic        read_internal, write_internal, cache_ext_en;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  chipset_shadow_cfg i_chipset_shadow_cfg (.*);

  // {index, data, mem address, exp read_internal, exp write_internal}
  localparam logic [37:0] VEC [14] = '{
    {8'h04, 8'h01, 20'hC0000, 1'b1, 1'b0},  // R5 granule0 read
    {8'h04, 8'h02, 20'hC0000, 1'b0, 1'b1},  // R5 granule0 write
    {8'h04, 8'h0C, 20'hC4000, 1'b1, 1'b1},  // R5 granule1 both
    {8'h04, 8'h0C, 20'hC0000, 1'b0, 1'b0},  // R5 granule0 cleared
    {8'h04, 8'h30, 20'hC8000, 1'b1, 1'b1},  // R5 granule2
    {8'h04, 8'h80, 20'hCFFFF, 1'b0, 1'b1},  // R5 granule3 write only
    {8'h05, 8'h40, 20'hDC000, 1'b1, 1'b0},  // R5 D granule3 read
    {8'h05, 8'h40, 20'hCC000, 1'b0, 1'b1},  // R5 C unaffected by D
    {8'h05, 8'h04, 20'hD4000, 1'b1, 1'b0},  // R5 D granule1
    {8'h06, 8'h01, 20'hE8000, 1'b1, 1'b0},  // R6 E read
    {8'h06, 8'h0E, 20'hEFFFF, 1'b0, 1'b1},  // R6 E write
    {8'h06, 8'h0E, 20'hF0000, 1'b1, 1'b1},  // R6 F both
    {8'h06, 8'h08, 20'hFFFFF, 1'b0, 1'b1},  // R6 F write only
    {8'h06, 8'h08, 20'hBFFFF, 1'b0, 1'b0}   // R7 below window
  };

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic io_write(logic [15:0] a, logic [7:0] d);
    @(negedge clk);
    io_addr = a; io_wdata = d; io_wr = 1;
    @(negedge clk);
    io_wr = 0;
  endtask

  task automatic set_reg(logic [7:0] idx, logic [7:0] d);
    io_write(16'h0022, idx);
    io_write(16'h0024, d);
  endtask

  task automatic read_chk(string req, logic [15:0] a, logic [7:0] exp);
    @(negedge clk);
    io_addr = a; io_rd = 1;
    #1 check(req, 32'(io_rdata), 32'(exp));
    io_rd = 0;
  endtask

  task automatic reg_chk(string req, logic [7:0] idx, logic [7:0] exp);
    io_write(16'h0022, idx);
    read_chk(req, 16'h0024, exp);
  endtask

  task automatic route_chk(string req, logic [19:0] a, logic v, logic er, logic ew);
    @(negedge clk);
    mem_addr = a; mem_valid = v;
    #1 check(req, 32'({read_internal, write_internal}), 32'({er, ew}));
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(4 * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // R9 reset state
    for (int i = 0; i < 18; i++) reg_chk("R9 reset reg", 8'(i), 8'h00);
    route_chk("R9 reset C", 20'hC0000, 1, 0, 0);
    route_chk("R9 reset F", 20'hFFFFF, 1, 0, 0);
    check("R9 reset cache", 32'(cache_ext_en), 0);
    // R2 other addresses
    read_chk("R2 index port read", 16'h0022, 8'hFF);
    read_chk("R2 unrelated port", 16'h0080, 8'hFF);

    foreach (VEC[k]) begin
      set_reg(VEC[k][37:30], VEC[k][29:22]);
      route_chk($sformatf("R5/R6/R7 vector %0d", k), VEC[k][21:2], 1, VEC[k][1], VEC[k][0]);
    end

    // R7 valid low
    route_chk("R7 valid low", 20'hF0000, 0, 0, 0);

    // R1 / R4 masking
    set_reg(8'h00, 8'hFF); reg_chk("R4 reg00 mask", 8'h00, 8'h7F);
    set_reg(8'h0C, 8'hFF); reg_chk("R4 reg0C mask", 8'h0C, 8'hCF);
    set_reg(8'h11, 8'hFF); reg_chk("R4 reg11 full", 8'h11, 8'hFF);
    set_reg(8'h03, 8'h5A); reg_chk("R1 write readback", 8'h03, 8'h5A);

    // R3 unimplemented indices
    set_reg(8'h12, 8'hAA); read_chk("R3 read at 12h", 16'h0024, 8'h00);
    set_reg(8'hFF, 8'h55); read_chk("R3 read at FFh", 16'h0024, 8'h00);
    reg_chk("R3 reg00 kept", 8'h00, 8'h7F);
    reg_chk("R3 reg11 kept", 8'h11, 8'hFF);
    reg_chk("R3 reg06 kept", 8'h06, 8'h08);

    // R8 cache flag
    set_reg(8'h02, 8'h04); check("R8 bit2", 32'(cache_ext_en), 1);
    set_reg(8'h02, 8'h08); check("R8 bit3", 32'(cache_ext_en), 1);
    set_reg(8'h02, 8'hF3); check("R8 other bits", 32'(cache_ext_en), 0);

    // R10 update timing: reg06 holds 08h
    io_write(16'h0022, 8'h06);
    @(negedge clk);
    mem_addr = 20'hF0000; mem_valid = 1;
    io_addr = 16'h0024; io_wdata = 8'h0C; io_wr = 1;
    #1 check("R10 old setting in write cycle", 32'({read_internal, write_internal}), 32'b01);
    @(negedge clk);
    io_wr = 0;
    #1 check("R10 new setting next cycle", 32'({read_internal, write_internal}), 32'b11);

    // R9 reset again
    @(negedge clk); rst = 1;
    @(negedge clk); rst = 0;
    route_chk("R9 reset clears routing", 20'hF0000, 1, 0, 0);
    read_chk("R9 index cleared reads reg00", 16'h0024, 8'h00);

    finish_run();
  end
endmodule